// File: doc/BRIEF.md
# Dual-Role SPI Shift Engine with Multi-Master Collision Detect

This block moves one 8-bit or 16-bit word, most significant bit first, across a four-wire full-duplex SPI bus. The same engine can act as the bus master or as a slave. In master mode it produces the serial clock from the system clock through a programmable divider and drives the select line itself. In slave mode it follows a clock and select driven from outside, and feeds those pins through two-stage synchronisers. Every pin comes out as an input, an output value and an output enable, so a pad ring or an open-drain wrapper can be added outside. The bus runs in mode 0: data is captured on the rising clock edge and launched on the falling edge.

A transfer starts with a valid/ready handshake on the transmit port. `tx_ready` is high only while the engine is idle. A word is taken on a cycle where `tx_valid` and `tx_ready` are both high. The word received comes back as a one-cycle `rx_valid` pulse with `rx_data`. That port has no ready signal and offers no back-pressure: the consumer must capture the word in the cycle it is shown. In master mode, the select input reports whether another master holds the bus. If that input reads active when a transfer starts or while one runs, the engine stops the transfer, lets go of its drivers and raises a sticky collision flag.

Top module: `spi_dual_engine`

## Requirements
- R1: In master mode the serial clock idles low. Each half period lasts `cfg_div`+1 system clocks, so `cfg_div`=0 gives the fastest rate, system clock / 2. The first rising edge comes `cfg_div`+1 clocks after the accepting edge.
- R2: Frames are 16 bits when `cfg_wide`=1 and 8 bits when `cfg_wide`=0. In 8-bit frames the word sits in bits [7:0]. Data goes out MSB first. The master shows the MSB from the accepting edge onward and moves to the next bit only on falling clock edges.
- R3: The master samples `miso_i` on each rising edge. On the last rising edge, `rx_valid` pulses for exactly one cycle and `rx_data` holds the received word. For 8-bit frames, bits [15:8] of `rx_data` are zero.
- R4: `cfg_ssel_pol`=1 makes select active high, and 0 makes it active low. The master drives select active from the accepting edge to the end of the frame. After the last rising edge, the clock stays high for one more half period. The clock then falls, and select and all master drivers are released in that same edge.
- R5: `tx_ready` is high exactly when the engine is idle. A word is accepted on `tx_valid && tx_ready`. `rx_valid` is a single-cycle pulse with no back-pressure.
- R6: If the synchronised select input turns active during a master transfer, the engine reacts on the third clock edge after the input changes. `collision` goes to 1, the clock, data and select enables drop, and no `rx_valid` is produced.
- R7: If the select input is already active when a master transfer is accepted, `collision` is set on that edge and the engine stays idle without driving any pin.
- R8: `collision` stays set until the next accepted transfer that does not itself collide. That transfer clears it.
- R9: In slave mode, with a transfer armed by the handshake and select active, the engine captures `mosi_i` on each rising edge of an outside clock as fast as system clock / 4. It pulses `rx_valid` once, with the word, after the last rising edge.
- R10: In slave mode, `miso_oe` is high only while the engine is armed and selected. `miso_o` gives the armed word MSB first and advances on each falling clock edge.
- R11: If select goes inactive in the middle of a slave frame, the frame is dropped. No `rx_valid` is produced, and the engine returns to idle with `tx_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_wide | input | 1 | 1 = 16-bit frame, 0 = 8-bit frame |
| cfg_div | input | 8 | Half-period length minus one, in system clocks |
| cfg_ssel_pol | input | 1 | Active level of the select line |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Engine idle, word will be taken |
| tx_data | input | 16 | Word to shift out |
| rx_valid | output | 1 | One-cycle pulse, received word present |
| rx_data | output | 16 | Received word |
| collision | output | 1 | Sticky multi-master collision flag |
| sclk_i | input | 1 | Serial clock pin, input side |
| sclk_o | output | 1 | Serial clock pin, output value |
| sclk_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out line, input side |
| mosi_o | output | 1 | Master-out line, output value |
| mosi_oe | output | 1 | Master-out output enable |
| miso_i | input | 1 | Master-in line, input side |
| miso_o | output | 1 | Master-in line, output value |
| miso_oe | output | 1 | Master-in output enable |
| ssel_i | input | 1 | Select line, input side |
| ssel_o | output | 1 | Select line, output value |
| ssel_oe | output | 1 | Select output enable |

## Verification
A bad half-period counter or bit counter shows up on `sclk_o` or `rx_valid` within one half period. The bench predicts both pins for every clock of a master frame. A shifter that loads or shifts wrongly shows up on `mosi_o` at the next falling edge, or in `rx_data` on the final rising edge. If the collision path or the select synchroniser is wrong, the enables still fail to drop three clocks after the select input changes, or the flag clears without a new transfer. In the slave role, a missed clock edge leaves `rx_valid` absent or the word shifted one place, at the end of the frame.

// File: rtl/spi_pkg.sv
package spi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_MRUN  = 3'd1,
    ST_MTAIL = 3'd2,
    ST_SARM  = 3'd3,
    ST_SACT  = 3'd4
  } spi_state_e;

  localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/spi_baud.sv
module spi_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              wide,
  input  logic              sample,
  input  logic              in_bit,
  input  logic              shift,
  output logic              out_bit,
  output logic [DATA_W-1:0] word_o
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] sh;
  logic              held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      held <= 1'b0;
    end else begin
      if (load)       sh <= load_data;
      else if (shift) sh <= {sh[DATA_W-2:0], held};
      if (sample)     held <= in_bit;
    end
  end

  assign out_bit = wide ? sh[DATA_W-1] : sh[HALF_W-1];
  assign word_o  = wide ? {sh[DATA_W-2:0], in_bit}
                        : {{HALF_W{1'b0}}, sh[HALF_W-2:0], in_bit};

endmodule

// File: rtl/spi_dual_engine.sv
module spi_dual_engine
  import spi_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic              cfg_wide,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_ssel_pol,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              collision,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              ssel_i,
  output logic              ssel_o,
  output logic              ssel_oe
);

  localparam int HALF_W = DATA_W / 2;
  localparam int CNT_W  = $clog2(DATA_W);

  spi_state_e       st;
  logic             sclk_r;
  logic             sclk_q;
  logic [CNT_W-1:0] bitcnt;
  logic [CNT_W-1:0] last_idx;
  logic [2:0]       pins_raw;
  logic [2:0]       pins_s;
  logic             ssel_s, sclk_s, mosi_s;
  logic             act_sel;
  logic             accept;
  logic             m_busy, tick;
  logic             m_rise, m_fall, s_rise, s_fall;
  logic             do_sample, do_shift, in_bit, out_bit, is_last;
  logic [DATA_W-1:0] word_now;

  assign pins_raw = {ssel_i, sclk_i, mosi_i};

  spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  assign ssel_s  = pins_s[2];
  assign sclk_s  = pins_s[1];
  assign mosi_s  = pins_s[0];
  assign act_sel = (ssel_s == cfg_ssel_pol);

  assign m_busy   = (st == ST_MRUN) || (st == ST_MTAIL);
  assign tx_ready = (st == ST_IDLE);
  assign accept   = tx_valid && tx_ready;

  spi_baud #(.DIV_W(DIV_W)) u_baud (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (m_busy),
    .div   (cfg_div),
    .tick  (tick)
  );

  assign m_rise = (st == ST_MRUN) && !act_sel && tick && !sclk_r;
  assign m_fall = (st == ST_MRUN) && !act_sel && tick &&  sclk_r;
  assign s_rise = (st == ST_SACT) && act_sel && sclk_s && !sclk_q;
  assign s_fall = (st == ST_SACT) && act_sel && !sclk_s && sclk_q;

  assign do_sample = m_rise || s_rise;
  assign do_shift  = m_fall || s_fall;
  assign in_bit    = (st == ST_MRUN) ? miso_i : mosi_s;
  assign last_idx  = cfg_wide ? CNT_W'(DATA_W - 1) : CNT_W'(HALF_W - 1);
  assign is_last   = (bitcnt == last_idx);

  spi_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data (tx_data),
    .wide      (cfg_wide),
    .sample    (do_sample),
    .in_bit    (in_bit),
    .shift     (do_shift),
    .out_bit   (out_bit),
    .word_o    (word_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      sclk_r    <= 1'b0;
      bitcnt    <= '0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      collision <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          sclk_r <= 1'b0;
          bitcnt <= '0;
          if (accept) begin
            if (cfg_master && act_sel) begin
              collision <= 1'b1;
            end else begin
              collision <= 1'b0;
              st        <= cfg_master ? ST_MRUN : ST_SARM;
            end
          end
        end
        ST_MRUN: begin
          if (act_sel) begin
            collision <= 1'b1;
            sclk_r    <= 1'b0;
            st        <= ST_IDLE;
          end else if (m_rise) begin
            sclk_r <= 1'b1;
            if (is_last) begin
              rx_valid <= 1'b1;
              rx_data  <= word_now;
              st       <= ST_MTAIL;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end else if (m_fall) begin
            sclk_r <= 1'b0;
          end
        end
        ST_MTAIL: begin
          if (act_sel) begin
            collision <= 1'b1;
            sclk_r    <= 1'b0;
            st        <= ST_IDLE;
          end else if (tick) begin
            sclk_r <= 1'b0;
            st     <= ST_IDLE;
          end
        end
        ST_SARM: begin
          bitcnt <= '0;
          if (act_sel) st <= ST_SACT;
        end
        ST_SACT: begin
          if (!act_sel) begin
            st <= ST_IDLE;
          end else if (s_rise) begin
            if (is_last) begin
              rx_valid <= 1'b1;
              rx_data  <= word_now;
              st       <= ST_IDLE;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sclk_o  = sclk_r;
  assign sclk_oe = m_busy;
  assign mosi_o  = out_bit;
  assign mosi_oe = m_busy;
  assign ssel_o  = m_busy ? cfg_ssel_pol : ~cfg_ssel_pol;
  assign ssel_oe = m_busy;
  assign miso_o  = out_bit;
  assign miso_oe = (st == ST_SACT);

endmodule

// File: rtl/spi_dual_engine_chk.sv
module spi_dual_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_master,
  input logic cfg_ssel_pol,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic collision,
  input logic sclk_o,
  input logic sclk_oe,
  input logic mosi_o,
  input logic mosi_oe,
  input logic miso_oe,
  input logic ssel_o,
  input logic ssel_oe
);

  a_r2_mosi_stable_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_oe && $rose(sclk_o)) |-> $stable(mosi_o));

  a_r3_rx_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r4_ssel_level: assert property (@(posedge clk) disable iff (!rst_n)
    ssel_oe |-> (ssel_o == cfg_ssel_pol));

  a_r5_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!sclk_oe && !miso_oe && !mosi_oe));

  a_r6_collision_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(collision) |-> (!sclk_oe && !mosi_oe && !ssel_oe && !rx_valid));

  a_r8_collision_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (collision && !(tx_valid && tx_ready)) |=> collision);

  a_r10_miso_slave_only: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> !cfg_master);

endmodule

bind spi_dual_engine spi_dual_engine_chk u_chk (.*);

// File: tb/spi_dual_engine_tb.sv
module spi_dual_engine_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_master, cfg_wide, cfg_ssel_pol;
  logic [7:0]  cfg_div;
  logic        tx_valid, tx_ready;
  logic [15:0] tx_data, rx_data;
  logic        rx_valid, collision;
  logic        sclk_i, sclk_o, sclk_oe;
  logic        mosi_i, mosi_o, mosi_oe;
  logic        miso_i, miso_o, miso_oe;
  logic        ssel_i, ssel_o, ssel_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  int rx_cnt = 0;
  logic [15:0] rx_seen = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_dual_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_wide(cfg_wide),
    .cfg_div(cfg_div), .cfg_ssel_pol(cfg_ssel_pol), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .collision(collision), .sclk_i(sclk_i),
    .sclk_o(sclk_o), .sclk_oe(sclk_oe), .mosi_i(mosi_i), .mosi_o(mosi_o),
    .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .ssel_i(ssel_i), .ssel_o(ssel_o), .ssel_oe(ssel_oe)
  );

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      rx_cnt  = rx_cnt + 1;
      rx_seen = rx_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference model of a master frame, one comparison per clock.
  task automatic master_xfer(input bit wide, input int div, input bit pol,
                             input logic [15:0] txd, input logic [15:0] mp);
    int n = wide ? 16 : 8;
    int h = div + 1;
    int idx;
    logic [15:0] exp_rx;
    @(negedge clk);
    cfg_master = 1'b1; cfg_wide = wide; cfg_div = 8'(div);
    cfg_ssel_pol = pol; ssel_i = ~pol; tx_data = txd;
    repeat (3) @(negedge clk);
    miso_i   = mp[n-1];
    tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    exp_rx = wide ? mp : {8'h00, mp[7:0]};
    for (int t = 0; t < 2*n*h; t++) begin
      idx = n - 1 - t / (2*h);
      chk(sclk_o == (((t / h) % 2) == 1) && sclk_oe, "R1", "sclk",
          int'(sclk_o), (t / h) % 2);
      chk(mosi_o == txd[idx] && mosi_oe, "R2", "mosi", int'(mosi_o), int'(txd[idx]));
      chk(ssel_o == pol && ssel_oe, "R4", "ssel", int'(ssel_o), int'(pol));
      chk(!tx_ready, "R5", "ready while busy", int'(tx_ready), 0);
      chk(rx_valid == (t == (2*n-1)*h), "R3", "rx_valid",
          int'(rx_valid), int'(t == (2*n-1)*h));
      if (t == (2*n-1)*h)
        chk(rx_data == exp_rx, "R3", "rx_data", int'(rx_data), int'(exp_rx));
      chk(!collision, "R8", "collision clear", int'(collision), 0);
      miso_i = mp[idx];
      @(negedge clk);
    end
    chk(!sclk_o && !sclk_oe && !ssel_oe && !mosi_oe, "R4", "release after frame",
        int'({sclk_o, sclk_oe, ssel_oe, mosi_oe}), 0);
    chk(tx_ready, "R5", "ready after frame", int'(tx_ready), 1);
  endtask

  task automatic slave_xfer(input bit wide, input int p, input bit pol,
                            input logic [15:0] txd, input logic [15:0] mp,
                            input bit chk_miso);
    int n = wide ? 16 : 8;
    logic [15:0] exp_rx;
    @(negedge clk);
    cfg_master = 1'b0; cfg_wide = wide; cfg_ssel_pol = pol;
    ssel_i = ~pol; sclk_i = 1'b0;
    repeat (3) @(negedge clk);
    tx_data = txd; tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    rx_cnt = 0;
    chk(!miso_oe, "R10", "miso_oe before select", int'(miso_oe), 0);
    ssel_i = pol;
    repeat (4) @(negedge clk);
    if (chk_miso) chk(miso_oe, "R10", "miso_oe when selected", int'(miso_oe), 1);
    for (int i = n - 1; i >= 0; i--) begin
      mosi_i = mp[i]; sclk_i = 1'b0;
      repeat (p) @(negedge clk);
      sclk_i = 1'b1;
      if (chk_miso) chk(miso_o == txd[i], "R10", "miso bit", int'(miso_o), int'(txd[i]));
      repeat (p) @(negedge clk);
    end
    sclk_i = 1'b0;
    repeat (p) @(negedge clk);
    exp_rx = wide ? mp : {8'h00, mp[7:0]};
    chk(rx_cnt == 1, "R9", "slave rx pulses", rx_cnt, 1);
    chk(rx_seen == exp_rx, "R9", "slave rx word", int'(rx_seen), int'(exp_rx));
    ssel_i = ~pol;
    repeat (4) @(negedge clk);
    chk(!miso_oe, "R10", "miso_oe after deselect", int'(miso_oe), 0);
    chk(tx_ready, "R5", "slave ready", int'(tx_ready), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_master = 1'b1; cfg_wide = 1'b0; cfg_div = 8'd0; cfg_ssel_pol = 1'b0;
    tx_valid = 1'b0; tx_data = '0;
    sclk_i = 1'b0; mosi_i = 1'b0; miso_i = 1'b0; ssel_i = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_ready && !rx_valid && !collision, "R5", "reset state",
        int'({tx_ready, rx_valid, collision}), 4);
    chk(!sclk_oe && !mosi_oe && !ssel_oe && !miso_oe, "R4", "reset enables",
        int'({sclk_oe, mosi_oe, ssel_oe, miso_oe}), 0);

    // Master frames: several widths, dividers and select levels
    master_xfer(1'b0, 2, 1'b0, 16'h00A5, 16'h003C);
    master_xfer(1'b1, 0, 1'b1, 16'hBEEF, 16'h1234);
    master_xfer(1'b0, 1, 1'b1, 16'hFF81, 16'h00C3);
    master_xfer(1'b1, 3, 1'b0, 16'h8001, 16'hA55A);

    // R6: collision in the middle of a master frame
    @(negedge clk);
    cfg_master = 1'b1; cfg_wide = 1'b0; cfg_div = 8'd3; cfg_ssel_pol = 1'b0; ssel_i = 1'b1;
    repeat (3) @(negedge clk);
    rx_cnt = 0;
    tx_data = 16'h005A; tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (5) @(negedge clk);
    ssel_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!collision && sclk_oe, "R6", "no reaction before third edge",
        int'({collision, sclk_oe}), 1);
    @(negedge clk);
    chk(collision, "R6", "collision flag", int'(collision), 1);
    chk(!sclk_oe && !mosi_oe && !ssel_oe, "R6", "drivers released",
        int'({sclk_oe, mosi_oe, ssel_oe}), 0);
    chk(tx_ready, "R6", "idle after abort", int'(tx_ready), 1);
    repeat (40) @(negedge clk);
    chk(rx_cnt == 0, "R6", "no rx after abort", rx_cnt, 0);
    ssel_i = 1'b1;
    repeat (4) @(negedge clk);

    // R7: select already active when the transfer is offered
    ssel_i = 1'b0;
    repeat (3) @(negedge clk);
    tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    chk(collision, "R7", "collision at start", int'(collision), 1);
    chk(!sclk_oe && !ssel_oe && !mosi_oe && tx_ready, "R7", "stays idle",
        int'({sclk_oe, ssel_oe, mosi_oe, tx_ready}), 1);
    ssel_i = 1'b1;
    repeat (6) @(negedge clk);
    chk(collision, "R8", "flag sticky while idle", int'(collision), 1);
    master_xfer(1'b0, 0, 1'b0, 16'h0066, 16'h0099);
    chk(!collision, "R8", "flag cleared by new transfer", int'(collision), 0);

    // Slave frames
    slave_xfer(1'b0, 2, 1'b0, 16'h0000, 16'h00B6, 1'b0);
    slave_xfer(1'b1, 2, 1'b1, 16'h0000, 16'hC3A1, 1'b0);
    slave_xfer(1'b1, 8, 1'b0, 16'h9E37, 16'h4D2B, 1'b1);
    slave_xfer(1'b0, 8, 1'b1, 16'h00D2, 16'h0071, 1'b1);

    // R11: deselect in the middle of a slave frame
    @(negedge clk);
    cfg_master = 1'b0; cfg_wide = 1'b0; cfg_ssel_pol = 1'b1; ssel_i = 1'b0; sclk_i = 1'b0;
    repeat (3) @(negedge clk);
    tx_data = 16'h00F0; tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    rx_cnt = 0;
    ssel_i = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      mosi_i = i[0]; sclk_i = 1'b0;
      repeat (4) @(negedge clk);
      sclk_i = 1'b1;
      repeat (4) @(negedge clk);
    end
    sclk_i = 1'b0;
    repeat (4) @(negedge clk);
    ssel_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(rx_cnt == 0, "R11", "no rx on aborted frame", rx_cnt, 0);
    chk(tx_ready && !miso_oe, "R11", "idle after deselect",
        int'({tx_ready, miso_oe}), 2);
    slave_xfer(1'b0, 2, 1'b1, 16'h0000, 16'h005C, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule